// File: doc/BRIEF.md
# Control Space Map Access Decoder

This block sits between the processor bus and the address translator. It watches every access. It acts only on accesses tagged with function code 3, the control address space. The top address nibble picks one of nine targets:

- the page map and the segment map, whose storage lives in the translator;
- four byte-wide system registers kept inside the block: context, system enable, user DMA enable and diagnostic LED;
- a read-only bus error register;
- two external byte sources: the ID PROM and a serial bypass port.

For map accesses, address bits 27 down to 13 are passed on as the entry index. The current context goes with them, so the translator addresses the entry for that page in the active context. The two low address bits and the access size decide which byte lanes of a 32-bit page map entry are written or returned.

Every accepted access runs through a three-state sequence:

| State | Transitions and outputs |
|---|---|
| IDLE | Waits for a strobe. Leaves on ACCEPT (a strobe with function code 3) to ISSUE. |
| ISSUE | Drives the target select, the write enable, the byte-lane enables and the steered write data. Internal registers are written on the clock edge that ends this state. Goes unconditionally to REPLY (FINISH). |
| REPLY | Raises the acknowledge for one cycle and presents the read data, right-justified. Goes unconditionally back to IDLE (RELEASE). |

Map storage is expected to return read data one clock after its select is seen.

Top module: `ctlspace_decoder`

## Requirements
- R1: A strobe whose function code is not 3 (codes 1, 2, 5, 6 and 7 included) produces no select, no acknowledge and no change to any internal register.
- R2: The address nibble [31:28] selects the target: 0 is the ID PROM, 1 the page map, 2 the segment map, 3 the context register, 4 the system enable register, 5 the user DMA enable register, 6 the bus error register, 7 the LED register and F the serial bypass. At most one external select is high at a time.
- R3: During ISSUE, the page map index equals address [27:13] and the segment map index equals address [27:17]. The context output carries the current context with them, so different contexts reach different entries.
- R4: Page map writes are steered big-endian. Size is encoded as 0 for byte, 1 for word and 2 for long.
  - A byte at offset k enables lane bit 3-k, and the byte is replicated in all lanes.
  - A word enables lanes 1100 when address bit 1 is 0 and 0011 when it is 1, and the half-word is replicated.
  - A long enables all four lanes.
- R5: Page map reads return the addressed byte, word or long, right-justified with zeros above. Byte offset 0 is bits [31:24] of the entry.
- R6: The context register stores only write data bits [2:0]. Reads return it zero-extended, and the context output follows it.
- R7: The system enable, user DMA enable and LED registers are written from data bits [7:0] and read back zero-extended. The LED output is active-low: 0 lights a LED. It resets to 8'hFF (all dark); the two enable registers reset to 0.
- R8: The bus error register loads the error-cause input on any cycle where the load input is high, and processor writes to it are ignored. A read whose REPLY cycle coincides with a load returns the value held before that load.
- R9: Nibbles 8 through E are unmapped. Reads of them return zero, writes to them change nothing, and both are still acknowledged.
- R10: An accepted strobe raises the target select on the following cycle and the acknowledge one cycle after that. Strobes that arrive while an access is in progress are dropped.
- R11: Segment map, ID PROM and serial accesses are byte-wide. Writes present the byte on lane data [7:0], and reads return the byte input zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc | input | 3 | Processor function code |
| addr | input | 32 | Access address |
| size | input | 2 | 0 byte, 1 word, 2 long |
| wdata | input | 32 | Write data, right-justified |
| rd_stb | input | 1 | Read request pulse |
| wr_stb | input | 1 | Write request pulse |
| err_load | input | 1 | Load strobe for the bus error register |
| err_cause | input | 8 | Error cause value to load |
| pmap_rdata | input | 32 | Page map entry read back from the translator |
| smap_rdata | input | 8 | Segment map entry read back |
| idprom_rdata | input | 8 | ID PROM byte |
| serial_rdata | input | 8 | Serial bypass byte |
| pmap_sel | output | 1 | Page map access cycle |
| smap_sel | output | 1 | Segment map access cycle |
| idprom_sel | output | 1 | ID PROM access cycle |
| serial_sel | output | 1 | Serial bypass access cycle |
| map_we | output | 1 | Write enable for the selected map |
| lane_en | output | 4 | Byte-lane enables, bit 3 is bits [31:24] |
| lane_data | output | 32 | Lane-steered write data |
| pmap_idx | output | 15 | Page map entry index |
| smap_idx | output | 11 | Segment map entry index |
| ctx_cur | output | 3 | Current context |
| sys_enable | output | 8 | System enable register |
| udma_enable | output | 8 | User DMA enable register |
| led_n | output | 8 | LED drive, 0 lit |
| ack | output | 1 | Access complete |
| rdata | output | 32 | Read data, valid with ack |

## Verification
Two events can land in the same cycle: a processor read of the bus error register and a hardware load of that register. The bench reads the register and raises the load input exactly in that read's REPLY cycle. The read must return the older cause, and a second read must then show the newly loaded one. A related overlap is a second strobe arriving while the first access is still in ISSUE. That strobe must be dropped, which the scoreboard judges by flagging any acknowledge it was not expecting.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int DATA_W  = 32;
    localparam int NLANES  = DATA_W / 8;
    localparam logic [2:0] FC_CTL = 3'd3;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef enum logic [3:0] {
        T_IDPROM = 4'd0,
        T_PMAP   = 4'd1,
        T_SMAP   = 4'd2,
        T_CTX    = 4'd3,
        T_SYSEN  = 4'd4,
        T_UDMA   = 4'd5,
        T_BUSERR = 4'd6,
        T_LED    = 4'd7,
        T_SERIAL = 4'd8,
        T_NONE   = 4'd9
    } target_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_REPLY = 2'd2
    } state_t;

endpackage

// File: rtl/cs_target_decode.sv
module cs_target_decode
    import cs_pkg::*;
(
    input  logic [3:0] nib,
    output target_t    tgt
);
    always_comb begin
        case (nib)
            4'h0:    tgt = T_IDPROM;
            4'h1:    tgt = T_PMAP;
            4'h2:    tgt = T_SMAP;
            4'h3:    tgt = T_CTX;
            4'h4:    tgt = T_SYSEN;
            4'h5:    tgt = T_UDMA;
            4'h6:    tgt = T_BUSERR;
            4'h7:    tgt = T_LED;
            4'hF:    tgt = T_SERIAL;
            default: tgt = T_NONE;   // 8..E unmapped
        endcase
    end
endmodule

// File: rtl/cs_lane_steer.sv
module cs_lane_steer
    import cs_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] entry,
    output logic [NLANES-1:0] lane_en,
    output logic [DATA_W-1:0] lane_data,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] shifted;
    assign shifted = entry >> {~off, 3'b000};

    always_comb begin
        case (size)
            SZ_BYTE: begin
                lane_en   = 4'b1000 >> off;
                lane_data = {NLANES{wdata[7:0]}};
                rd_val    = {24'b0, shifted[7:0]};
            end
            SZ_WORD: begin
                lane_en   = off[1] ? 4'b0011 : 4'b1100;
                lane_data = {2{wdata[15:0]}};
                rd_val    = {16'b0, (off[1] ? entry[15:0] : entry[31:16])};
            end
            default: begin
                lane_en   = '1;
                lane_data = wdata;
                rd_val    = entry;
            end
        endcase
    end
endmodule

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs
    import cs_pkg::*;
#(
    parameter int CTX_W = 3,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  target_t          tgt,
    input  logic [REG_W-1:0] wbyte,
    input  logic             err_load,
    input  logic [REG_W-1:0] err_cause,
    output logic [CTX_W-1:0] ctx,
    output logic [REG_W-1:0] sysen,
    output logic [REG_W-1:0] udma,
    output logic [REG_W-1:0] led_n,
    output logic [REG_W-1:0] buserr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx    <= '0;
            sysen  <= '0;
            udma   <= '0;
            led_n  <= '1;
            buserr <= '0;
        end else begin
            if (wr_en) begin
                case (tgt)
                    T_CTX:   ctx   <= wbyte[CTX_W-1:0];
                    T_SYSEN: sysen <= wbyte;
                    T_UDMA:  udma  <= wbyte;
                    T_LED:   led_n <= wbyte;
                    default: ;
                endcase
            end
            if (err_load) buserr <= err_cause;
        end
    end

    // R8: processor write never alters the bus error register
    a_r8_buserr_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == T_BUSERR && !err_load) |=> $stable(buserr));

    // R7: LED register only moves on a write aimed at it
    a_r7_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tgt == T_LED) |=> $stable(led_n));
endmodule

// File: rtl/ctlspace_decoder.sv
module ctlspace_decoder
    import cs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PG_SHIFT = 13,
    parameter int SG_SHIFT = 17,
    parameter int CTX_W    = 3,
    parameter int REG_W    = 8,
    localparam int IDX_TOP = ADDR_W - 5,
    localparam int PIDX_W  = IDX_TOP - PG_SHIFT + 1,
    localparam int SIDX_W  = IDX_TOP - SG_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        fc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              err_load,
    input  logic [REG_W-1:0]  err_cause,
    input  logic [DATA_W-1:0] pmap_rdata,
    input  logic [REG_W-1:0]  smap_rdata,
    input  logic [REG_W-1:0]  idprom_rdata,
    input  logic [REG_W-1:0]  serial_rdata,
    output logic              pmap_sel,
    output logic              smap_sel,
    output logic              idprom_sel,
    output logic              serial_sel,
    output logic              map_we,
    output logic [NLANES-1:0] lane_en,
    output logic [DATA_W-1:0] lane_data,
    output logic [PIDX_W-1:0] pmap_idx,
    output logic [SIDX_W-1:0] smap_idx,
    output logic [CTX_W-1:0]  ctx_cur,
    output logic [REG_W-1:0]  sys_enable,
    output logic [REG_W-1:0]  udma_enable,
    output logic [REG_W-1:0]  led_n,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    state_t            state, nstate;
    target_t           tgt_in, tgt_q;
    logic              accept, wr_q, reg_wr;
    logic [1:0]        size_q, off_q;
    logic [PIDX_W-1:0] pidx_q;
    logic [DATA_W-1:0] wdata_q, rd_ext;
    logic [REG_W-1:0]  buserr;

    assign accept = (state == ST_IDLE) && (rd_stb || wr_stb) && (fc == FC_CTL);

    cs_target_decode u_dec (
        .nib (addr[ADDR_W-1 -: 4]),
        .tgt (tgt_in)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  nstate = accept ? ST_ISSUE : ST_IDLE;   // ACCEPT
            ST_ISSUE: nstate = ST_REPLY;                      // FINISH
            ST_REPLY: nstate = ST_IDLE;                       // RELEASE
            default:  nstate = ST_IDLE;
        endcase
    end

    // Capture the request on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= T_NONE;
            wr_q    <= 1'b0;
            size_q  <= '0;
            off_q   <= '0;
            pidx_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            tgt_q   <= tgt_in;
            wr_q    <= wr_stb;
            size_q  <= size;
            off_q   <= addr[1:0];
            pidx_q  <= addr[IDX_TOP:PG_SHIFT];
            wdata_q <= wdata;
        end
    end

    cs_lane_steer u_lane (
        .size      (size_q),
        .off       (off_q),
        .wdata     (wdata_q),
        .entry     (pmap_rdata),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .rd_val    (rd_ext)
    );

    cs_ctrl_regs #(.CTX_W(CTX_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .tgt       (tgt_q),
        .wbyte     (wdata_q[REG_W-1:0]),
        .err_load  (err_load),
        .err_cause (err_cause),
        .ctx       (ctx_cur),
        .sysen     (sys_enable),
        .udma      (udma_enable),
        .led_n     (led_n),
        .buserr    (buserr)
    );

    assign pmap_idx = pidx_q;
    assign smap_idx = pidx_q[PIDX_W-1 -: SIDX_W];

    // Outputs per state
    always_comb begin
        pmap_sel   = 1'b0;
        smap_sel   = 1'b0;
        idprom_sel = 1'b0;
        serial_sel = 1'b0;
        map_we     = 1'b0;
        reg_wr     = 1'b0;
        ack        = 1'b0;
        rdata      = '0;
        unique case (state)
            ST_IDLE: ;
            ST_ISSUE: begin
                pmap_sel   = (tgt_q == T_PMAP);
                smap_sel   = (tgt_q == T_SMAP);
                idprom_sel = (tgt_q == T_IDPROM);
                serial_sel = (tgt_q == T_SERIAL);
                map_we     = wr_q && (tgt_q == T_PMAP || tgt_q == T_SMAP);
                reg_wr     = wr_q;
            end
            ST_REPLY: begin
                ack = 1'b1;
                if (!wr_q) begin
                    case (tgt_q)
                        T_PMAP:   rdata = rd_ext;
                        T_SMAP:   rdata = {{(DATA_W-REG_W){1'b0}}, smap_rdata};
                        T_IDPROM: rdata = {{(DATA_W-REG_W){1'b0}}, idprom_rdata};
                        T_SERIAL: rdata = {{(DATA_W-REG_W){1'b0}}, serial_rdata};
                        T_CTX:    rdata = {{(DATA_W-CTX_W){1'b0}}, ctx_cur};
                        T_SYSEN:  rdata = {{(DATA_W-REG_W){1'b0}}, sys_enable};
                        T_UDMA:   rdata = {{(DATA_W-REG_W){1'b0}}, udma_enable};
                        T_BUSERR: rdata = {{(DATA_W-REG_W){1'b0}}, buserr};
                        T_LED:    rdata = {{(DATA_W-REG_W){1'b0}}, led_n};
                        default:  rdata = '0;
                    endcase
                end
            end
            default: ;
        endcase
    end

    // R10: acknowledge two cycles after an accepted strobe
    a_r10_ack_timing: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 ack);

    // R1: foreign function codes select nothing
    a_r1_foreign_fc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (rd_stb || wr_stb) && fc != FC_CTL)
        |=> !(pmap_sel || smap_sel || idprom_sel || serial_sel));

    // R2: at most one external select at a time
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pmap_sel, smap_sel, idprom_sel, serial_sel}));

    // R9: unmapped targets read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && tgt_q == T_NONE) |-> rdata == '0);

    // R6: context reads carry no upper bits
    a_r6_ctx_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && tgt_q == T_CTX) |-> rdata[DATA_W-1:CTX_W] == '0);

    // R4: a map write always enables some lane
    a_r4_lanes_live: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |-> lane_en != '0);
endmodule

// File: tb/ctlspace_decoder_test.sv
module ctlspace_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fc = '0;
    logic [31:0] addr = '0;
    logic [1:0]  size = '0;
    logic [31:0] wdata = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, err_load = 1'b0;
    logic [7:0]  err_cause = '0;
    logic [31:0] pmap_rdata;
    logic [7:0]  smap_rdata;
    logic [7:0]  idprom_rdata = 8'hC3;
    logic [7:0]  serial_rdata = 8'h7E;
    logic        pmap_sel, smap_sel, idprom_sel, serial_sel, map_we, ack;
    logic [3:0]  lane_en;
    logic [31:0] lane_data, rdata;
    logic [14:0] pmap_idx;
    logic [10:0] smap_idx;
    logic [2:0]  ctx_cur;
    logic [7:0]  sys_enable, udma_enable, led_n;

    int checks = 0, failures = 0;
    bit done = 0;

    ctlspace_decoder uut (.*);

    always #4 clk = ~clk;

    // Map storage model: registered read, lane-merged write
    logic [31:0] pm [int];
    logic [7:0]  sm [int];
    logic [31:0] pm_q = '0;
    logic [7:0]  sm_q = '0;
    assign pmap_rdata = pm_q;
    assign smap_rdata = sm_q;

    always @(posedge clk) begin
        if (pmap_sel) begin
            int k;
            logic [31:0] old;
            k = int'({ctx_cur, pmap_idx});
            old = pm.exists(k) ? pm[k] : 32'h0;
            pm_q <= old;
            if (map_we) begin
                for (int i = 0; i < 4; i++)
                    if (lane_en[i]) old[i*8 +: 8] = lane_data[i*8 +: 8];
                pm[k] = old;
            end
        end
        if (smap_sel) begin
            int k;
            k = int'({ctx_cur, smap_idx});
            sm_q <= sm.exists(k) ? sm[k] : 8'h0;
            if (map_we) sm[k] = lane_data[7:0];
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard queues: bit 32 = compare data
    logic [32:0] q_exp [$];
    string       q_req [$];

    always @(negedge clk) begin
        if (rst_n && ack) begin
            if (q_exp.size() == 0) begin
                check(0, "R1/R10 unexpected ack", 32'h1, 32'h0);
            end else begin
                logic [32:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                if (e[32]) check(rdata == e[31:0], r, rdata, e[31:0]);
            end
        end
    end

    // exp_sel = {pmap, smap, idprom, serial}, checked in the ISSUE cycle
    task automatic acc(input logic [2:0] f, input logic [31:0] a, input logic [1:0] sz,
                       input logic [31:0] d, input bit wr, input bit expect_ack,
                       input logic [31:0] exp, input logic [3:0] exp_sel, input string req);
        @(negedge clk);
        fc = f; addr = a; size = sz; wdata = d;
        rd_stb = !wr; wr_stb = wr;
        if (expect_ack) begin
            q_exp.push_back({!wr, exp});
            q_req.push_back(req);
        end
        @(negedge clk);
        rd_stb = 0; wr_stb = 0;
        check({pmap_sel, smap_sel, idprom_sel, serial_sel} == exp_sel, {req, " sel"},
              {28'h0, pmap_sel, smap_sel, idprom_sel, serial_sel}, {28'h0, exp_sel});
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state (R7, R6, R10)
        check(led_n == 8'hFF, "R7 led reset", {24'h0, led_n}, 32'hFF);
        check(sys_enable == 0 && udma_enable == 0, "R7 enable reset",
              {16'h0, sys_enable, udma_enable}, 32'h0);
        check(ctx_cur == 0, "R6 ctx reset", {29'h0, ctx_cur}, 32'h0);
        check(ack == 0, "R10 idle ack", {31'h0, ack}, 32'h0);

        // R6: only low 3 bits stored
        acc(3'd3, 32'h3000_0000, 2'd0, 32'hFD, 1, 1, 0, 4'b0000, "R6 ctx write");
        acc(3'd3, 32'h3000_0000, 2'd0, 0, 0, 1, 32'h5, 4'b0000, "R6 ctx read");
        check(ctx_cur == 3'd5, "R6 ctx out", {29'h0, ctx_cur}, 32'h5);

        // R4/R5: page map lanes, index 1
        @(negedge clk);
        fc = 3; addr = 32'h1000_2000; size = 2; wdata = 32'h1122_3344; wr_stb = 1;
        q_exp.push_back({1'b0, 32'h0}); q_req.push_back("R4 long write");
        @(negedge clk);
        wr_stb = 0;
        check(pmap_idx == 15'd1, "R3 pmap idx", {17'h0, pmap_idx}, 32'h1);
        check(lane_en == 4'b1111 && map_we, "R4 long lanes", {27'h0, map_we, lane_en}, 32'h1F);
        repeat (2) @(negedge clk);
        acc(3, 32'h1000_2000, 2, 0, 0, 1, 32'h1122_3344, 4'b1000, "R5 long read");
        acc(3, 32'h1000_2002, 0, 32'hAA, 1, 1, 0, 4'b1000, "R4 byte write");
        acc(3, 32'h1000_2000, 2, 0, 0, 1, 32'h1122_AA44, 4'b1000, "R4 byte merge");
        acc(3, 32'h1000_2001, 0, 0, 0, 1, 32'h22, 4'b1000, "R5 byte read");
        acc(3, 32'h1000_2000, 1, 32'hBEEF, 1, 1, 0, 4'b1000, "R4 word write");
        acc(3, 32'h1000_2000, 2, 0, 0, 1, 32'hBEEF_AA44, 4'b1000, "R4 word merge");
        acc(3, 32'h1000_2002, 1, 0, 0, 1, 32'hAA44, 4'b1000, "R5 word read");

        // R3: another context sees another entry
        acc(3, 32'h3000_0000, 0, 32'h2, 1, 1, 0, 4'b0000, "R3 ctx switch");
        acc(3, 32'h1000_2000, 2, 0, 0, 1, 32'h0, 4'b1000, "R3 other context");
        acc(3, 32'h3000_0000, 0, 32'h5, 1, 1, 0, 4'b0000, "R3 ctx back");
        acc(3, 32'h1000_2000, 2, 0, 0, 1, 32'hBEEF_AA44, 4'b1000, "R3 context restored");

        // R11: segment map, index 2
        @(negedge clk);
        fc = 3; addr = 32'h2004_0000; size = 0; wdata = 32'h5A; wr_stb = 1;
        q_exp.push_back({1'b0, 32'h0}); q_req.push_back("R11 smap write");
        @(negedge clk);
        wr_stb = 0;
        check(smap_sel && smap_idx == 11'd2, "R3 smap idx", {21'h0, smap_idx}, 32'h2);
        check(lane_data[7:0] == 8'h5A, "R11 smap data", lane_data, 32'h5A);
        repeat (2) @(negedge clk);
        acc(3, 32'h2004_0000, 0, 0, 0, 1, 32'h5A, 4'b0100, "R11 smap read");

        // R1: foreign codes ignored
        acc(3'd5, 32'h7000_0000, 0, 32'h00, 1, 0, 0, 4'b0000, "R1 fc5 write");
        acc(3'd1, 32'h1000_2000, 2, 0, 0, 0, 0, 4'b0000, "R1 fc1 read");
        acc(3'd7, 32'h3000_0000, 0, 32'h1, 1, 0, 0, 4'b0000, "R1 fc7 write");
        check(led_n == 8'hFF && ctx_cur == 3'd5, "R1 no change",
              {21'h0, ctx_cur, led_n}, {21'h0, 3'd5, 8'hFF});

        // R7: system registers
        acc(3, 32'h7000_0000, 0, 32'h0F, 1, 1, 0, 4'b0000, "R7 led write");
        check(led_n == 8'h0F, "R7 led out", {24'h0, led_n}, 32'h0F);
        acc(3, 32'h7000_0000, 0, 0, 0, 1, 32'h0F, 4'b0000, "R7 led read");
        acc(3, 32'h4000_0000, 0, 32'h81, 1, 1, 0, 4'b0000, "R7 sysen write");
        acc(3, 32'h5000_0000, 0, 32'h3C, 1, 1, 0, 4'b0000, "R7 udma write");
        acc(3, 32'h4000_0000, 0, 0, 0, 1, 32'h81, 4'b0000, "R7 sysen read");
        acc(3, 32'h5000_0000, 0, 0, 0, 1, 32'h3C, 4'b0000, "R7 udma read");

        // R8: bus error register
        @(negedge clk); err_load = 1; err_cause = 8'h42;
        @(negedge clk); err_load = 0;
        acc(3, 32'h6000_0000, 0, 0, 0, 1, 32'h42, 4'b0000, "R8 buserr read");
        acc(3, 32'h6000_0000, 0, 32'h99, 1, 1, 0, 4'b0000, "R8 buserr write");
        acc(3, 32'h6000_0000, 0, 0, 0, 1, 32'h42, 4'b0000, "R8 write ignored");
        // load in the REPLY cycle of a read
        @(negedge clk);
        fc = 3; addr = 32'h6000_0000; size = 0; rd_stb = 1;
        q_exp.push_back({1'b1, 32'h42}); q_req.push_back("R8 concurrent load old");
        @(negedge clk); rd_stb = 0;
        @(negedge clk); err_load = 1; err_cause = 8'h77;
        @(negedge clk); err_load = 0;
        acc(3, 32'h6000_0000, 0, 0, 0, 1, 32'h77, 4'b0000, "R8 concurrent load new");

        // R9: unmapped nibble
        acc(3, 32'h9000_0000, 2, 32'hDEAD_BEEF, 1, 1, 0, 4'b0000, "R9 unmapped write");
        acc(3, 32'h9000_0000, 2, 0, 0, 1, 32'h0, 4'b0000, "R9 unmapped read");
        acc(3, 32'hE000_0004, 2, 0, 0, 1, 32'h0, 4'b0000, "R9 unmapped E");

        // R2: external byte sources
        acc(3, 32'h0000_0000, 0, 0, 0, 1, 32'hC3, 4'b0010, "R2 idprom read");
        acc(3, 32'hF000_0000, 0, 0, 0, 1, 32'h7E, 4'b0001, "R2 serial read");

        // R10: a strobe during ISSUE is dropped
        @(negedge clk);
        fc = 3; addr = 32'h7000_0000; size = 0; rd_stb = 1;
        q_exp.push_back({1'b1, 32'h0F}); q_req.push_back("R10 first access");
        @(negedge clk);
        addr = 32'h4000_0000;
        check(ack == 0, "R10 no early ack", {31'h0, ack}, 32'h0);
        @(negedge clk); rd_stb = 0;
        repeat (4) @(negedge clk);
        check(q_exp.size() == 0, "R10 queue drained", q_exp.size(), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule